// File: doc/BRIEF.md
# Level Interrupt End-of-Interrupt Receiver

This block sits on the I/O side of a two-bit serial interrupt bus. It owns a small table of interrupt entries. Each entry has a vector, a level/edge mode bit, a mask bit and a remote-pending bit. When an unmasked level-mode line is high and its pending bit is clear, the block issues a one-cycle delivery strobe and sets the pending bit. While that bit stays set, the line is not delivered again.

The block watches the bus for an end-of-interrupt message. It follows the start cycle and the four arbitration-ID cycles, collects the 8-bit vector two bits per cycle, and counts on to the end of the 14-cycle frame. Once the frame has finished, every level entry whose vector matches has its pending bit cleared. A line that is still high is then delivered again as a fresh interrupt.

The bus also carries other message kinds. The block does not decode their contents. It works out how long each one is and skips over it, and ignores the bus until that message ends.

Top module: `eoi_level_rx`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pend_o` and `new_irq_o` are all zero.
- R2: When entry i has `level_i[i]`=1, `mask_i[i]`=0, `irq_i[i]`=1 and `pend_o[i]`=0 in a cycle, the next clock edge sets both `new_irq_o[i]` and `pend_o[i]`. `new_irq_o[i]` is high for exactly one cycle.
- R3: While `pend_o[i]` is 1, `new_irq_o[i]` stays 0 in the following cycle, whatever `irq_i[i]` does.
- R4: An entry with `mask_i[i]`=1 or `level_i[i]`=0 never raises `new_irq_o[i]` and never sets `pend_o[i]`.
- R5: A frame begins in any idle cycle where `bus_i[0]`=1. That cycle is cycle 1. If `bus_i[1]`=1 in cycle 1, the frame is an end-of-interrupt frame of 14 cycles.
- R6: In an end-of-interrupt frame, the vector is `{c6[1],c6[0],c7[1],c7[0],c8[1],c8[0],c9[1],c9[0]}`, where cN is `bus_i` in cycle N. Bus values in cycles 2–5 and 10–14 have no effect.
- R7: The edge that ends cycle 14 arms the clear. On the next edge, every entry with `level_i`=1, a matching vector and `pend_o`=1 drops `pend_o`.
- R8: If `irq_i[i]` is still high and the entry is unmasked once its pending bit has been cleared, then on the following edge `new_irq_o[i]` pulses and `pend_o[i]` is set again. If the line is low, `pend_o[i]` stays 0.
- R9: An end-of-interrupt clears all matching level entries at once. Entries whose vector differs, and edge-mode entries, keep their pending bit.
- R10: In a frame whose cycle-1 `bus_i[1]` is 0, the value of `bus_i` in cycle 6 sets the frame length: 2'b10 gives 33 cycles, 2'b11 gives 39 cycles, and anything else gives 21 cycles. No pending bit changes because of the bus contents of such a frame.
- R11: A new frame may start in the cycle right after the last cycle of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 2 | Serial interrupt bus bits [1:0] |
| vec_tbl_i | input | NUM_ENT*8 | Vector of entry i in bits [8i+7:8i] |
| level_i | input | NUM_ENT | 1 = level mode, 0 = edge mode |
| mask_i | input | NUM_ENT | 1 = entry masked |
| irq_i | input | NUM_ENT | Interrupt input lines |
| pend_o | output | NUM_ENT | Remote-pending bits |
| new_irq_o | output | NUM_ENT | One-cycle delivery strobes |

## Verification
The hardest case to reach is a frame whose length the block must decode correctly or it will go wrong. To reach it, the bench sends a 39-cycle frame that contains a complete, valid end-of-interrupt frame at cycle 22, which is where a receiver that decoded 21 cycles would start looking for the next frame. It also sends 21- and 33-cycle frames, each followed at once by a real end-of-interrupt frame, so a receiver that counted too far would miss that frame's start cycle. Before these frames, the lines of the targeted entries are driven low, so a clear that should not happen, or one that is missed, shows up as a lasting difference on `pend_o`.

// File: rtl/eoi_rx_pkg.sv
package eoi_rx_pkg;
  localparam int unsigned SYM_W      = 2;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned CYC_W      = 6;
  localparam int unsigned EOI_LEN    = 14;
  localparam int unsigned SHORT_LEN  = 21;
  localparam int unsigned LOWPRI_LEN = 33;
  localparam int unsigned RDREQ_LEN  = 39;
  localparam int unsigned TYPE_CYC   = 6;
  localparam int unsigned VEC_FIRST  = 6;
  localparam int unsigned VEC_LAST   = VEC_FIRST + VEC_W / SYM_W - 1;

  typedef enum logic {ST_IDLE, ST_BODY} frm_st_e;

  function automatic logic [CYC_W-1:0] msg_len(input logic [SYM_W-1:0] code);
    case (code)
      2'b10:   msg_len = CYC_W'(LOWPRI_LEN);
      2'b11:   msg_len = CYC_W'(RDREQ_LEN);
      default: msg_len = CYC_W'(SHORT_LEN);
    endcase
  endfunction
endpackage

// File: rtl/eoi_rx_frame.sv
module eoi_rx_frame
  import eoi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SYM_W-1:0]  bus_i,
  output logic              eoi_stb_o,
  output logic [VEC_W-1:0]  eoi_vec_o
);
  frm_st_e          st_q;
  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] len_q;
  logic             eoi_q;
  logic [VEC_W-1:0] vec_q;
  logic             stb_q;

  logic in_vec;
  logic last_cyc;

  assign in_vec   = eoi_q && (cyc_q >= CYC_W'(VEC_FIRST)) && (cyc_q <= CYC_W'(VEC_LAST));
  assign last_cyc = (cyc_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
      len_q <= CYC_W'(SHORT_LEN);
      eoi_q <= 1'b0;
      vec_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (bus_i[0]) begin
          st_q  <= ST_BODY;
          cyc_q <= CYC_W'(2);
          eoi_q <= bus_i[1];
          len_q <= bus_i[1] ? CYC_W'(EOI_LEN) : CYC_W'(SHORT_LEN);
        end
      end else begin
        cyc_q <= cyc_q + 1'b1;
        if (!eoi_q && cyc_q == CYC_W'(TYPE_CYC)) len_q <= msg_len(bus_i);
        if (in_vec) vec_q <= {vec_q[VEC_W-SYM_W-1:0], bus_i};
        if (last_cyc) begin
          st_q  <= ST_IDLE;
          stb_q <= eoi_q;
        end
      end
    end
  end

  assign eoi_stb_o = stb_q;
  assign eoi_vec_o = vec_q;
endmodule

// File: rtl/eoi_rx_entry.sv
module eoi_rx_entry
  import eoi_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] vec_cfg_i,
  input  logic             level_i,
  input  logic             mask_i,
  input  logic             irq_i,
  input  logic             eoi_stb_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output logic             pend_o,
  output logic             dlv_o
);
  logic pend_q, dlv_q;
  logic hit, fire;

  assign hit  = eoi_stb_i && level_i && (vec_cfg_i == eoi_vec_i);
  assign fire = level_i && !mask_i && irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dlv_q  <= 1'b0;
    end else begin
      dlv_q <= 1'b0;
      if (pend_q) begin
        if (hit) pend_q <= 1'b0;
      end else if (fire) begin
        pend_q <= 1'b1;
        dlv_q  <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign dlv_o  = dlv_q;
endmodule

// File: rtl/eoi_level_rx.sv
module eoi_level_rx
  import eoi_rx_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               bus_i,
  input  logic [NUM_ENT*VEC_W-1:0] vec_tbl_i,
  input  logic [NUM_ENT-1:0]       level_i,
  input  logic [NUM_ENT-1:0]       mask_i,
  input  logic [NUM_ENT-1:0]       irq_i,
  output logic [NUM_ENT-1:0]       pend_o,
  output logic [NUM_ENT-1:0]       new_irq_o
);
  logic             eoi_stb;
  logic [VEC_W-1:0] eoi_vec;

  eoi_rx_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_i     (bus_i),
    .eoi_stb_o (eoi_stb),
    .eoi_vec_o (eoi_vec)
  );

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    eoi_rx_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vec_cfg_i (vec_tbl_i[i*VEC_W +: VEC_W]),
      .level_i   (level_i[i]),
      .mask_i    (mask_i[i]),
      .irq_i     (irq_i[i]),
      .eoi_stb_i (eoi_stb),
      .eoi_vec_i (eoi_vec),
      .pend_o    (pend_o[i]),
      .dlv_o     (new_irq_o[i])
    );
  end
endmodule

// File: rtl/eoi_level_rx_chk.sv
module eoi_level_rx_chk #(
  parameter int unsigned NUM_ENT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_ENT-1:0] level_i,
  input logic [NUM_ENT-1:0] mask_i,
  input logic [NUM_ENT-1:0] pend_o,
  input logic [NUM_ENT-1:0] new_irq_o,
  input logic               eoi_stb
);
  AST_DLV_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_irq_o & ~pend_o) == '0); // R2

  AST_DLV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (new_irq_o & $past(new_irq_o)) == '0); // R2

  AST_NO_DLV_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (new_irq_o & $past(pend_o)) == '0); // R3

  AST_MASK_EDGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (new_irq_o & ($past(mask_i) | ~$past(level_i))) == '0); // R4

  AST_EOI_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_stb |=> !eoi_stb); // R5

  AST_CLEAR_NEEDS_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~pend_o & $past(pend_o) & ~{NUM_ENT{$past(eoi_stb)}}) == '0); // R7
endmodule

bind eoi_level_rx eoi_level_rx_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .level_i   (level_i),
  .mask_i    (mask_i),
  .pend_o    (pend_o),
  .new_irq_o (new_irq_o),
  .eoi_stb   (eoi_stb)
);

// File: tb/eoi_level_rx_tb.sv
module eoi_level_rx_tb;
  localparam int NE = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    bus_i = 2'b00;
  logic [NE*8-1:0] vec_tbl_i;
  logic [NE-1:0] level_i, mask_i, irq_i;
  logic [NE-1:0] pend_o, new_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  eoi_level_rx #(.NUM_ENT(NE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(bus_i), .vec_tbl_i(vec_tbl_i),
    .level_i(level_i), .mask_i(mask_i), .irq_i(irq_i),
    .pend_o(pend_o), .new_irq_o(new_irq_o)
  );

  always #5 clk_i = ~clk_i;

  // behavioural reference: frame collected as a symbol queue
  logic [1:0] q[$];
  bit         m_busy;
  int         m_len;
  bit         m_stb;
  logic [7:0] m_svec;
  logic [NE-1:0] m_pend, m_dlv;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      q.delete(); m_busy = 0; m_len = 21; m_stb = 0; m_svec = 0;
      m_pend = '0; m_dlv = '0;
    end else begin
      bit nstb;
      for (int i = 0; i < NE; i++) begin
        m_dlv[i] = 1'b0;
        if (m_pend[i]) begin
          if (m_stb && level_i[i] && vec_tbl_i[i*8 +: 8] == m_svec) m_pend[i] = 1'b0;
        end else if (level_i[i] && !mask_i[i] && irq_i[i]) begin
          m_pend[i] = 1'b1;
          m_dlv[i]  = 1'b1;
        end
      end
      nstb = 0;
      if (!m_busy) begin
        if (bus_i[0]) begin
          q.delete(); q.push_back(bus_i); m_busy = 1;
          m_len = bus_i[1] ? 14 : 21;
        end
      end else begin
        q.push_back(bus_i);
        if (q.size() == 6 && !q[0][1])
          m_len = (bus_i == 2'b11) ? 39 : (bus_i == 2'b10) ? 33 : 21;
        if (q.size() == m_len) begin
          m_busy = 0;
          if (q[0][1]) begin
            nstb = 1;
            m_svec = {q[5], q[6], q[7], q[8]};
          end
        end
      end
      m_stb = nstb;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (pend_o !== m_pend || new_irq_o !== m_dlv) begin
        errors++;
        $display("FAIL %s model: pend=%h irq=%h expected pend=%h irq=%h",
                 cur_req, pend_o, new_irq_o, m_pend, m_dlv);
      end
    end
  end

  task automatic chk(input string req, input logic [NE-1:0] act, input logic [NE-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [1:0] tx[$];

  task automatic add_eoi(input logic [7:0] v, input logic [1:0] junk);
    tx.push_back(2'b11);
    for (int k = 0; k < 4; k++) tx.push_back({k[0], 1'b0});
    for (int k = 3; k >= 0; k--) tx.push_back(v[2*k +: 2]);
    for (int k = 0; k < 5; k++) tx.push_back(junk);
  endtask

  task automatic send();
    while (tx.size() > 0) begin
      bus_i = tx.pop_front();
      @(negedge clk_i);
    end
    bus_i = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) vec_tbl_i[i*8 +: 8] = 8'h20 + 8'(i);
    vec_tbl_i[5*8 +: 8] = 8'h23;
    level_i = 8'hBF;
    mask_i  = 8'h80;
    irq_i   = 8'h00;
    idle(3);
    chk("R1", pend_o, 8'h00);
    chk("R1", new_irq_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", pend_o | new_irq_o, 8'h00);

    cur_req = "R2";
    irq_i = 8'hFF;
    @(negedge clk_i);
    chk("R2", new_irq_o, 8'h3F);
    chk("R2", pend_o, 8'h3F);
    cur_req = "R3";
    @(negedge clk_i);
    chk("R3", new_irq_o, 8'h00);
    idle(4);
    chk("R3", new_irq_o, 8'h00);
    chk("R4", pend_o & 8'hC0, 8'h00);

    cur_req = "R7";
    add_eoi(8'h23, 2'b11);
    send();
    @(negedge clk_i);
    chk("R7", pend_o, 8'h17);
    chk("R9", pend_o & 8'h17, 8'h17);
    cur_req = "R8";
    @(negedge clk_i);
    chk("R8", new_irq_o, 8'h28);
    chk("R8", pend_o, 8'h3F);

    irq_i = 8'hF7;
    cur_req = "R6";
    add_eoi(8'h23, 2'b01);
    send();
    @(negedge clk_i);
    chk("R6", pend_o, 8'h17);
    @(negedge clk_i);
    chk("R8", new_irq_o, 8'h20);
    idle(3);
    chk("R8", pend_o, 8'h37);

    irq_i = 8'hF4;
    cur_req = "R10";
    tx.push_back(2'b01);
    for (int k = 0; k < 4; k++) tx.push_back(2'b00);
    tx.push_back(2'b00);
    for (int k = 0; k < 15; k++) tx.push_back(2'b01);
    add_eoi(8'h21, 2'b00);
    send();
    idle(2);
    chk("R11", pend_o, 8'h35);

    tx.push_back(2'b01);
    for (int k = 0; k < 4; k++) tx.push_back(2'b00);
    tx.push_back(2'b10);
    for (int k = 0; k < 27; k++) tx.push_back(2'b11);
    add_eoi(8'h20, 2'b10);
    send();
    idle(2);
    chk("R10", pend_o, 8'h34);

    irq_i = 8'hE4;
    tx.push_back(2'b01);
    for (int k = 0; k < 4; k++) tx.push_back(2'b00);
    tx.push_back(2'b11);
    for (int k = 0; k < 15; k++) tx.push_back(2'b00);
    add_eoi(8'h24, 2'b00);
    for (int k = 0; k < 4; k++) tx.push_back(2'b00);
    send();
    idle(3);
    chk("R10", pend_o, 8'h34);

    cur_req = "R9";
    add_eoi(8'h26, 2'b00);
    add_eoi(8'h99, 2'b00);
    send();
    idle(3);
    chk("R9", pend_o, 8'h34);
    add_eoi(8'h24, 2'b00);
    send();
    idle(2);
    chk("R9", pend_o, 8'h24);
    chk("R4", new_irq_o, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule